// File: doc/BRIEF.md
# Gather Address Generator

This unit produces one byte address per vector element for a gather load. It takes a 64-bit scalar base and a packed vector of per-element indices. Each index is narrowed and extended as the controls select, optionally doubled, and added to the base. Each lane's address is then gated by that lane's predicate bit. The result is registered once, so an operation presented with `in_valid` appears on the outputs exactly one clock later.

A memory pipeline uses `addr_en` to decide which lanes issue a request. A lane whose enable is low issues nothing. Its address output is held at zero, so no stale value can leak into a request.

Top module: `gather_addr_gen`

## Requirements
- R1: An active lane's address is `base_addr + (offset << scale)`, where the shift is 1 when `scale_half` is 1 and 0 otherwise. The sum wraps modulo 2^64 and no overflow is reported.
- R2: When a 32-bit offset is in use and `idx_signed` is 0, the low 32 bits of the lane's index are zero-extended to 64 bits.
- R3: When a 32-bit offset is in use and `idx_signed` is 1, the low 32 bits of the lane's index are sign-extended from bit 31.
- R4: When `wide_elem`=1 and `narrow_idx`=0, the lane's full 64-bit index is the offset and is treated as unsigned. `idx_signed` has no effect in this case.
- R5: The enable bit for lane e is `pred[e*ESIZE/8]`. That is `pred[4e]` for 32-bit elements and `pred[8e]` for 64-bit elements. The other predicate bits are ignored. A lane whose bit is 0 has `addr_en` 0 and an address of 0.
- R6: When `wide_elem`=0, the elements are 32 bits wide and there are VLEN/32 lanes. Lane e takes index bits [32e+31:32e] and always uses a 32-bit offset, whatever `narrow_idx` is.
- R7: When `wide_elem`=1, the elements are 64 bits wide. Lanes 0 to VLEN/64-1 take index bits [64e+63:64e]. The remaining lane slots have `addr_en` 0.
- R8: `out_valid` equals `in_valid` from the previous cycle. When `in_valid` was 0, every `addr_en` bit is 0.
- R9: While reset is active, `out_valid`, every `addr_en` bit and every address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| base_addr | input | 64 | Scalar base address |
| idx_vec | input | VLEN | Packed per-element indices |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| wide_elem | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| narrow_idx | input | 1 | With 64-bit elements, 1 selects a 32-bit offset |
| idx_signed | input | 1 | 32-bit offset extension: 0 zero, 1 sign |
| scale_half | input | 1 | 1 shifts the offset left by one |
| out_valid | output | 1 | Registered valid |
| addr_en | output | VLEN/32 | Per-lane request enable |
| addr_vec | output | 64*VLEN/32 | Per-lane addresses, lane e at [64e+63:64e] |

## Verification
The assertions check on every cycle that the valid path has a one-cycle latency. They also check that no enable appears without a valid, that the upper lane slots stay quiet for 64-bit elements, and that lane 0 follows its predicate bit and zeroes its address when inactive. The arithmetic itself is shown only by the bench's scenarios. These cover zero and sign extension of negative indices, full-width unsigned indices, scaling, wraparound past 2^64, and predicate patterns in which the ignored predicate bits are set.

// File: rtl/gather_addr_gen.sv
module gather_addr_gen #(
  parameter int VLEN = 256,
  localparam int PLEN = VLEN / 8,
  localparam int NE = VLEN / 32,
  localparam int NW = VLEN / 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       base_addr,
  input  logic [VLEN-1:0]   idx_vec,
  input  logic [PLEN-1:0]   pred,
  input  logic              wide_elem,
  input  logic              narrow_idx,
  input  logic              idx_signed,
  input  logic              scale_half,
  output logic              out_valid,
  output logic [NE-1:0]     addr_en,
  output logic [NE*64-1:0]  addr_vec
);

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  for (genvar g = 0; g < NE; g++) begin : g_lane
    logic [63:0] raw64;
    logic        wpred;
    logic [31:0] lo32;
    logic [63:0] off;
    logic [63:0] sum;
    logic        act;

    if (g < NW) begin : g_wide
      assign raw64 = idx_vec[g*64 +: 64];
      assign wpred = pred[g*8];
    end else begin : g_narrow_only
      assign raw64 = '0;
      assign wpred = 1'b0;
    end

    assign lo32 = wide_elem ? raw64[31:0] : idx_vec[g*32 +: 32];
    assign off  = (wide_elem && !narrow_idx) ? raw64
                : {{32{idx_signed & lo32[31]}}, lo32};
    assign sum  = base_addr + (scale_half ? {off[62:0], 1'b0} : off);
    assign act  = in_valid && (wide_elem ? wpred : pred[g*4]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_en[g]           <= 1'b0;
        addr_vec[g*64 +: 64] <= '0;
      end else begin
        addr_en[g]           <= act;
        addr_vec[g*64 +: 64] <= act ? sum : 64'd0;
      end
    end
  end

endmodule

module gather_addr_gen_chk #(
  parameter int NE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             wide_elem,
  input logic             pred0,
  input logic             out_valid,
  input logic [NE-1:0]    addr_en,
  input logic [NE*64-1:0] addr_vec
);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && addr_en == '0));

  a_r7_upper_slots_off: assert property (@(posedge clk) disable iff (!rst_n)
    wide_elem |=> (addr_en[NE-1:NE/2] == '0));

  a_r5_lane0_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred0) |=> !addr_en[0]);

  a_r5_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !addr_en[0]) |-> (addr_vec[63:0] == 64'd0));

endmodule

bind gather_addr_gen gather_addr_gen_chk #(.NE(NE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_elem(wide_elem),
  .pred0(pred[0]), .out_valid(out_valid), .addr_en(addr_en), .addr_vec(addr_vec)
);

// File: tb/gather_addr_gen_bench.sv
module gather_addr_gen_bench;
  localparam int VLEN = 256;
  localparam int PLEN = VLEN / 8;
  localparam int NE = VLEN / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] base_addr = '0;
  logic [VLEN-1:0] idx_vec = '0;
  logic [PLEN-1:0] pred = '0;
  logic wide_elem = 1'b0, narrow_idx = 1'b0, idx_signed = 1'b0, scale_half = 1'b0;
  logic out_valid;
  logic [NE-1:0] addr_en;
  logic [NE*64-1:0] addr_vec;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gather_addr_gen #(.VLEN(VLEN)) u_gather_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_addr(base_addr),
    .idx_vec(idx_vec), .pred(pred), .wide_elem(wide_elem), .narrow_idx(narrow_idx),
    .idx_signed(idx_signed), .scale_half(scale_half), .out_valid(out_valid),
    .addr_en(addr_en), .addr_vec(addr_vec)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req);
    logic [63:0] off, ea;
    logic en;
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    for (int e = 0; e < NE; e++) begin
      if (wide_elem) begin
        en = (e < NE / 2) ? pred[e*8] : 1'b0;
        if (e >= NE / 2) off = 0;
        else if (!narrow_idx) off = idx_vec[e*64 +: 64];
        else if (idx_signed) off = 64'($signed(idx_vec[e*64 +: 32]));
        else off = 64'(idx_vec[e*64 +: 32]);
      end else begin
        en = pred[e*4];
        if (idx_signed) off = 64'($signed(idx_vec[e*32 +: 32]));
        else off = 64'(idx_vec[e*32 +: 32]);
      end
      ea = en ? base_addr + off * (scale_half ? 64'd2 : 64'd1) : 64'd0;
      chk({req, " en"}, 64'(addr_en[e]), 64'(en));
      chk({req, " addr"}, addr_vec[e*64 +: 64], ea);
    end
  endtask

  task automatic t_reset();
    chk("R9 valid", 64'(out_valid), 64'd0);
    chk("R9 en", 64'(addr_en), 64'd0);
    chk("R9 addr0", addr_vec[63:0], 64'd0);
  endtask

  task automatic t_zext_r2();
    base_addr = 64'h0000_1000_0000_0000;
    for (int e = 0; e < NE; e++) idx_vec[e*32 +: 32] = 32'hF000_0010 + 32'(e * 4);
    pred = '1; wide_elem = 0; narrow_idx = 0; idx_signed = 0; scale_half = 0;
    run_op("R2 R6 zext");
  endtask

  task automatic t_sext_r3();
    base_addr = 64'h0000_0000_0000_8000;
    for (int e = 0; e < NE; e++) idx_vec[e*32 +: 32] = (e % 2) ? 32'hFFFF_FF00 : 32'h0000_0100;
    pred = '1; wide_elem = 0; narrow_idx = 1; idx_signed = 1; scale_half = 1;
    run_op("R3 R1 sext scaled");
  endtask

  task automatic t_full64_r4();
    base_addr = 64'h0000_0000_0000_0040;
    for (int e = 0; e < NE / 2; e++) idx_vec[e*64 +: 64] = 64'h8000_0001_8000_0000 + 64'(e);
    pred = '1; wide_elem = 1; narrow_idx = 0; idx_signed = 1; scale_half = 0;
    run_op("R4 R7 full64");
  endtask

  task automatic t_narrow64_r3();
    base_addr = 64'h0000_0000_1000_0000;
    for (int e = 0; e < NE / 2; e++) idx_vec[e*64 +: 64] = 64'h1234_5678_8000_0000 + 64'(e * 8);
    pred = '1; wide_elem = 1; narrow_idx = 1; idx_signed = 1; scale_half = 1;
    run_op("R3 R7 narrow64 sext");
    idx_signed = 0;
    run_op("R2 R7 narrow64 zext");
  endtask

  task automatic t_wrap_r1();
    base_addr = 64'hFFFF_FFFF_FFFF_FFF0;
    for (int e = 0; e < NE; e++) idx_vec[e*32 +: 32] = 32'h0000_0020 + 32'(e);
    pred = '1; wide_elem = 0; narrow_idx = 0; idx_signed = 0; scale_half = 1;
    run_op("R1 wrap");
  endtask

  task automatic t_pred_r5();
    base_addr = 64'h0000_0000_0000_2000;
    for (int e = 0; e < NE; e++) idx_vec[e*32 +: 32] = 32'(e * 16);
    wide_elem = 0; narrow_idx = 0; idx_signed = 0; scale_half = 0;
    pred = 32'hEEEE_EEE1;
    run_op("R5 pred32 ignored bits");
    pred = 32'h0000_0101 | 32'hFEFE_0000;
    wide_elem = 1;
    run_op("R5 pred64 ignored bits");
    pred = 32'h0001_0100;
    run_op("R5 pred64 alt lanes");
  endtask

  task automatic t_idle_r8();
    pred = '1; wide_elem = 0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle valid", 64'(out_valid), 64'd0);
    chk("R8 idle en", 64'(addr_en), 64'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zext_r2();
    t_sext_r3();
    t_full64_r4();
    t_narrow64_r3();
    t_wrap_r1();
    t_pred_r5();
    t_idle_r8();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule